// File: doc/BRIEF.md
# DMA Control/Status Register Bank with Dual Interrupt Routing

This block is the register bank of a multi-channel DMA controller. Software reaches it through a 32-bit register port with a byte address, write data, read data, a write strobe and a read strobe. The bank holds a few global registers and one group of eight registers per channel. Each channel takes three kinds of event pulses from the transfer engine: chunk finished, whole transfer finished, and error. The bank turns these into a per-channel pending flag. The pending flags are collected into two read-only source registers. Each source register is gated by its own mask register and drives its own interrupt line, A or B.

The transfer engine puts a 5-bit channel index on the selection input. The bank answers on dedicated outputs with that channel's control word, size, addresses, address masks and descriptor pointer. The number of channels is a parameter from 1 to 31.

The register port has no back-pressure. A write strobe is accepted in the cycle it is high and takes effect at the next clock edge. Read data is a combinational function of the address and of the current register state, so it is valid in the same cycle as the read strobe. A CSR read clears that channel's pending, done and error flags at the end of the read cycle. Event inputs are single-cycle pulses. Status inputs are plain levels.

Top module: `dma_csr_bank`

## Requirements
- R1: A synchronous active-high reset sets every stored register to zero. After reset, all reads return zero and both interrupt outputs are low.
- R2: The global control register at byte offset 0x000 is 32-bit read/write. Mask A sits at 0x004 and mask B at 0x008. Each mask stores only its low NCH bits; its upper bits read as zero.
- R3: The group of channel n starts at 0x020 + n*0x20. Word 0 of the group is the CSR. Words 1 to 7 are full 32-bit read/write registers, in this order: size, source address, source mask, destination address, destination mask, descriptor pointer, software pointer.
- R4: Source A at 0x00C and source B at 0x010 are read-only and ignore writes. Bit n of each is the pending flag of channel n.
- R5: CSR layout:
  - bits 6:0 are writable: bit0 enable, bit1 chunk interrupt enable, bit2 done interrupt enable, bit3 error interrupt enable, bits 6:4 priority.
  - bit8 shows the live busy input.
  - bit9 is the sticky done flag, bit10 the sticky error flag, bit11 the pending flag.
  - all other bits read as zero, and writes to bits 31:7 are ignored.
- R6: The pending flag is set by:
  - a chunk event while bit1 is set,
  - a done event while bit2 is set,
  - an error event while bit3 is set.
  
  An event whose enable bit is clear leaves pending unchanged. The done and error events set their sticky flags regardless of the enable bits.
- R7: A read of a channel CSR returns the flags as they were, then clears pending, done and error at that clock edge. If an event arrives in the same cycle as the read, the event wins and its flags stay set.
- R8: int_a is high exactly when some bit of source A is set together with the same bit of mask A. int_b follows the same rule with source B and mask B.
- R9: Reads of unimplemented offsets, of channels numbered NCH or above, or of addresses not word-aligned return zero. Writes to any of these change no register.
- R10: The engine outputs show the registers of the channel named by eng_sel. When eng_sel is NCH or above, every engine output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data (combinational) |
| ev_chunk | input | NCH | Per-channel chunk-complete pulse |
| ev_done | input | NCH | Per-channel transfer-complete pulse |
| ev_err | input | NCH | Per-channel error pulse |
| ch_busy | input | NCH | Per-channel busy level |
| eng_sel | input | 5 | Channel index presented to the engine |
| eng_csr | output | 32 | Selected channel CSR |
| eng_size | output | 32 | Selected channel size |
| eng_src | output | 32 | Selected source address |
| eng_src_mask | output | 32 | Selected source address mask |
| eng_dst | output | 32 | Selected destination address |
| eng_dst_mask | output | 32 | Selected destination address mask |
| eng_desc | output | 32 | Selected descriptor pointer |
| int_a | output | 1 | Interrupt line A |
| int_b | output | 1 | Interrupt line B |

## Verification
The assertions assume that the write and read strobes are never high together, and that the event inputs are single-cycle pulses sampled at the clock edge. The read-clear property also assumes that no event arrives for that channel in the read cycle; the event-wins case is left to a separate directed check. The stimulus respects these limits: it drives one strobe per bus cycle, changes all inputs just after a rising edge, and pulses each event for exactly one cycle. The one deliberate overlap is a read and an event in the same cycle, used only for the event-wins case.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  typedef logic [31:0] word_t;
  typedef logic [7:0][31:0] grp_t;

  localparam int GRP_WORDS = 8;
  localparam int CFG_W     = 7;

  localparam logic [2:0] G_CTRL  = 3'd0;
  localparam logic [2:0] G_MASKA = 3'd1;
  localparam logic [2:0] G_MASKB = 3'd2;
  localparam logic [2:0] G_SRCA  = 3'd3;
  localparam logic [2:0] G_SRCB  = 3'd4;

  localparam logic [2:0] W_CSR   = 3'd0;

  localparam int B_IE_CHUNK = 1;
  localparam int B_IE_DONE  = 2;
  localparam int B_IE_ERR   = 3;
  localparam int B_BUSY     = 8;
  localparam int B_DONE     = 9;
  localparam int B_ERR      = 10;
  localparam int B_PEND     = 11;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_csr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_hit,
  input  logic       rd_hit,
  input  logic [2:0] idx,
  input  word_t      wdata,
  input  logic       ev_chunk,
  input  logic       ev_done,
  input  logic       ev_err,
  input  logic       busy,
  output grp_t       view,
  output logic       pend
);
  logic [CFG_W-1:0]               cfg;
  logic                           done_st;
  logic                           err_st;
  logic [GRP_WORDS-2:0][31:0]     dreg;
  logic                           csr_rd;
  logic                           raise;

  assign csr_rd = rd_hit && (idx == W_CSR);
  assign raise  = (ev_chunk && cfg[B_IE_CHUNK]) ||
                  (ev_done  && cfg[B_IE_DONE])  ||
                  (ev_err   && cfg[B_IE_ERR]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      done_st <= 1'b0;
      err_st  <= 1'b0;
      pend    <= 1'b0;
      dreg    <= '0;
    end else begin
      if (wr_hit && idx == W_CSR) cfg <= wdata[CFG_W-1:0];
      if (wr_hit && idx != W_CSR) dreg[idx - 3'd1] <= wdata;
      if (raise)       pend <= 1'b1;
      else if (csr_rd) pend <= 1'b0;
      if (ev_done)     done_st <= 1'b1;
      else if (csr_rd) done_st <= 1'b0;
      if (ev_err)      err_st <= 1'b1;
      else if (csr_rd) err_st <= 1'b0;
    end
  end

  always_comb begin
    view            = '0;
    view[0][CFG_W-1:0] = cfg;
    view[0][B_BUSY] = busy;
    view[0][B_DONE] = done_st;
    view[0][B_ERR]  = err_st;
    view[0][B_PEND] = pend;
    for (int i = 1; i < GRP_WORDS; i++) view[i] = dreg[i-1];
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!pend && cfg == '0 && !done_st && !err_st));

  a_r6_done_sets_pend: assert property (@(posedge clk) disable iff (rst)
    (ev_done && cfg[B_IE_DONE]) |=> pend);

  a_r6_quiet_holds: assert property (@(posedge clk) disable iff (rst)
    (!pend && !ev_chunk && !ev_done && !ev_err) |=> !pend);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && idx == W_CSR && !ev_chunk && !ev_done && !ev_err) |=> (!pend && !done_st && !err_st));
endmodule

// File: rtl/dma_irq_route.sv
module dma_irq_route #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] src,
  output logic         irq
);
  assign irq = |(mask & src);

  a_r8_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> (mask != '0 && src != '0));

  a_r8_no_src_no_irq: assert property (@(posedge clk) disable iff (rst)
    (src == '0) |-> !irq);
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [9:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  input  logic           reg_we,
  input  logic           reg_re,
  output logic [31:0]    reg_rdata,
  input  logic [NCH-1:0] ev_chunk,
  input  logic [NCH-1:0] ev_done,
  input  logic [NCH-1:0] ev_err,
  input  logic [NCH-1:0] ch_busy,
  input  logic [4:0]     eng_sel,
  output logic [31:0]    eng_csr,
  output logic [31:0]    eng_size,
  output logic [31:0]    eng_src,
  output logic [31:0]    eng_src_mask,
  output logic [31:0]    eng_dst,
  output logic [31:0]    eng_dst_mask,
  output logic [31:0]    eng_desc,
  output logic           int_a,
  output logic           int_b
);
  localparam logic [4:0] NCH5 = 5'(NCH);

  logic       aligned;
  logic [4:0] grp;
  logic [4:0] ch_idx;
  logic [2:0] widx;
  logic       glob_hit;
  logic       chan_hit;

  assign aligned  = (reg_addr[1:0] == 2'b00);
  assign grp      = reg_addr[9:5];
  assign widx     = reg_addr[4:2];
  assign ch_idx   = grp - 5'd1;
  assign glob_hit = aligned && (grp == 5'd0);
  assign chan_hit = aligned && (grp != 5'd0) && (ch_idx < NCH5);

  word_t          ctrl_q;
  logic [NCH-1:0] mask_a_q;
  logic [NCH-1:0] mask_b_q;
  logic [NCH-1:0] pend_vec;
  grp_t           ch_view [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      mask_a_q <= '0;
      mask_b_q <= '0;
    end else if (reg_we && glob_hit) begin
      case (widx)
        G_CTRL:  ctrl_q   <= reg_wdata;
        G_MASKA: mask_a_q <= reg_wdata[NCH-1:0];
        G_MASKB: mask_b_q <= reg_wdata[NCH-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic sel;
    assign sel = chan_hit && (ch_idx == 5'(g));
    dma_chan_regs u_ch (
      .clk      (clk),
      .rst      (rst),
      .wr_hit   (reg_we && sel),
      .rd_hit   (reg_re && sel),
      .idx      (widx),
      .wdata    (reg_wdata),
      .ev_chunk (ev_chunk[g]),
      .ev_done  (ev_done[g]),
      .ev_err   (ev_err[g]),
      .busy     (ch_busy[g]),
      .view     (ch_view[g]),
      .pend     (pend_vec[g])
    );
  end

  dma_irq_route #(.N(NCH)) u_irq_a (
    .clk(clk), .rst(rst), .mask(mask_a_q), .src(pend_vec), .irq(int_a)
  );
  dma_irq_route #(.N(NCH)) u_irq_b (
    .clk(clk), .rst(rst), .mask(mask_b_q), .src(pend_vec), .irq(int_b)
  );

  always_comb begin
    reg_rdata = '0;
    if (glob_hit) begin
      case (widx)
        G_CTRL:  reg_rdata = ctrl_q;
        G_MASKA: reg_rdata[NCH-1:0] = mask_a_q;
        G_MASKB: reg_rdata[NCH-1:0] = mask_b_q;
        G_SRCA:  reg_rdata[NCH-1:0] = pend_vec;
        G_SRCB:  reg_rdata[NCH-1:0] = pend_vec;
        default: ;
      endcase
    end else if (chan_hit) begin
      for (int i = 0; i < NCH; i++)
        if (ch_idx == 5'(i)) reg_rdata = ch_view[i][widx];
    end
  end

  grp_t eng_grp;
  always_comb begin
    eng_grp = '0;
    for (int i = 0; i < NCH; i++)
      if (eng_sel == 5'(i)) eng_grp = ch_view[i];
  end

  assign eng_csr      = eng_grp[0];
  assign eng_size     = eng_grp[1];
  assign eng_src      = eng_grp[2];
  assign eng_src_mask = eng_grp[3];
  assign eng_dst      = eng_grp[4];
  assign eng_dst_mask = eng_grp[5];
  assign eng_desc     = eng_grp[6];

  a_r9_far_channel_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_re && grp != 5'd0 && ch_idx >= NCH5) |-> (reg_rdata == '0));

  a_r10_sel_oob_zero: assert property (@(posedge clk) disable iff (rst)
    (eng_sel >= NCH5) |-> (eng_csr == '0 && eng_size == '0 && eng_desc == '0));

  a_r2_ctrl_write_lands: assert property (@(posedge clk) disable iff (rst)
    (reg_we && aligned && reg_addr[9:2] == 8'd0) |=> (ctrl_q == $past(reg_wdata)));
endmodule

// File: tb/dma_csr_bank_tb.sv
`timescale 1ns/1ps
module dma_csr_bank_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [9:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic         reg_we = 1'b0;
  logic         reg_re = 1'b0;
  logic [31:0]  reg_rdata;
  logic [N-1:0] ev_chunk = '0, ev_done = '0, ev_err = '0, ch_busy = '0;
  logic [4:0]   eng_sel = '0;
  logic [31:0]  eng_csr, eng_size, eng_src, eng_src_mask, eng_dst, eng_dst_mask, eng_desc;
  logic         int_a, int_b;

  always #10 clk = ~clk;

  dma_csr_bank #(.NCH(N)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .ev_chunk(ev_chunk), .ev_done(ev_done), .ev_err(ev_err), .ch_busy(ch_busy),
    .eng_sel(eng_sel), .eng_csr(eng_csr), .eng_size(eng_size), .eng_src(eng_src),
    .eng_src_mask(eng_src_mask), .eng_dst(eng_dst), .eng_dst_mask(eng_dst_mask),
    .eng_desc(eng_desc), .int_a(int_a), .int_b(int_b)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [9:0] ch_addr(int ch, int w);
    return 10'(32 + ch*32 + w*4);
  endfunction

  task automatic compare(logic [31:0] act, logic [31:0] exp, string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (reg_re) begin
      if (exp_q.size() == 0) compare(reg_rdata, 32'hx, "scoreboard underflow");
      else compare(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    reg_addr = a; reg_re = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    reg_re = 1'b0;
  endtask

  task automatic pulse(logic [N-1:0] c, logic [N-1:0] d, logic [N-1:0] e);
    @(posedge clk); #1;
    ev_chunk = c; ev_done = d; ev_err = e;
    @(posedge clk); #1;
    ev_chunk = '0; ev_done = '0; ev_err = '0;
  endtask

  task automatic chk_irq(logic ea, logic eb, string tag);
    @(negedge clk);
    compare({31'd0, int_a}, {31'd0, ea}, {tag, " int_a"});
    compare({31'd0, int_b}, {31'd0, eb}, {tag, " int_b"});
  endtask

  bit done_flag = 0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    rd(10'h000, 32'h0, "R1 ctrl");
    rd(10'h004, 32'h0, "R1 maskA");
    rd(10'h00C, 32'h0, "R1 srcA");
    rd(ch_addr(0,0), 32'h0, "R1 ch0 csr");
    rd(ch_addr(2,1), 32'h0, "R1 ch2 size");
    chk_irq(1'b0, 1'b0, "R1");

    // R2: globals
    wr(10'h000, 32'hDEADBEEF); rd(10'h000, 32'hDEADBEEF, "R2 ctrl");
    wr(10'h004, 32'hFFFFFFFF); rd(10'h004, 32'h0000000F, "R2 maskA width");
    wr(10'h008, 32'h00000005); rd(10'h008, 32'h00000005, "R2 maskB");

    // R3: channel data registers
    for (int w = 1; w < 8; w++) wr(ch_addr(1,w), 32'h1000_0001 | (w << 8));
    for (int w = 1; w < 8; w++) rd(ch_addr(1,w), 32'h1000_0001 | (w << 8), "R3 ch1 word");
    wr(ch_addr(3,2), 32'hCAFE0003); rd(ch_addr(3,2), 32'hCAFE0003, "R3 ch3 src");
    rd(ch_addr(2,2), 32'h0, "R3 ch2 untouched");

    // R9: holes
    wr(ch_addr(4,1), 32'h12345678); rd(ch_addr(4,1), 32'h0, "R9 channel beyond NCH");
    rd(10'h014, 32'h0, "R9 unused global");
    wr(10'h041, 32'hFFFF0000); rd(ch_addr(1,0), 32'h0, "R9 misaligned write ignored");

    // R5: CSR writable field and busy
    wr(ch_addr(0,0), 32'hFFFFFFFF); rd(ch_addr(0,0), 32'h0000007F, "R5 csr mask");
    ch_busy = 4'b0100;
    rd(ch_addr(2,0), 32'h00000100, "R5 busy live");

    // R6/R8: chunk event on ch0
    pulse(4'b0001, 4'b0000, 4'b0000);
    rd(10'h00C, 32'h1, "R4 srcA pending");
    rd(10'h010, 32'h1, "R4 srcB pending");
    chk_irq(1'b1, 1'b1, "R8 both masked in");
    pulse(4'b0000, 4'b0010, 4'b0000);
    rd(10'h00C, 32'h1, "R6 disabled done no pend");
    wr(10'h00C, 32'hFFFFFFFF); rd(10'h00C, 32'h1, "R4 srcA write ignored");
    wr(10'h010, 32'h0);        rd(10'h010, 32'h1, "R4 srcB write ignored");
    wr(10'h008, 32'h2);
    chk_irq(1'b1, 1'b0, "R8 maskB excludes ch0");

    // R7: read clears
    rd(ch_addr(0,0), 32'h0000087F, "R7 csr with pend");
    rd(ch_addr(0,0), 32'h0000007F, "R7 csr cleared");
    rd(10'h00C, 32'h0, "R7 srcA cleared");
    chk_irq(1'b0, 1'b0, "R8 after clear");
    rd(ch_addr(1,0), 32'h00000200, "R6 sticky done");
    rd(ch_addr(1,0), 32'h00000000, "R7 done cleared");

    // R7: event in read cycle wins
    @(posedge clk); #1;
    reg_addr = ch_addr(0,0); reg_re = 1'b1; ev_chunk = 4'b0001;
    exp_q.push_back(32'h0000007F); tag_q.push_back("R7 same-cycle read");
    @(posedge clk); #1;
    reg_re = 1'b0; ev_chunk = '0;
    rd(ch_addr(0,0), 32'h0000087F, "R7 event wins");

    // R6: error with enable on ch2 (busy still high)
    wr(ch_addr(2,0), 32'h8);
    pulse(4'b0000, 4'b0000, 4'b0100);
    rd(10'h00C, 32'h4, "R6 err pend");
    rd(ch_addr(2,0), 32'h00000D08, "R6 err csr");

    // R10: engine view
    eng_sel = 5'd1;
    @(negedge clk);
    compare(eng_size, 32'h1000_0101, "R10 eng size ch1");
    compare(eng_desc, 32'h1000_0601, "R10 eng desc ch1");
    compare(eng_dst_mask, 32'h1000_0501, "R10 eng dst mask ch1");
    eng_sel = 5'd0;
    @(negedge clk);
    compare(eng_csr, 32'h0000007F, "R10 eng csr ch0");
    eng_sel = 5'd5;
    @(negedge clk);
    compare(eng_csr, 32'h0, "R10 eng oob csr");
    compare(eng_size, 32'h0, "R10 eng oob size");

    // R1: reset again
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    rd(10'h000, 32'h0, "R1 ctrl after reset");
    rd(ch_addr(1,3), 32'h0, "R1 ch1 reg after reset");
    chk_irq(1'b0, 1'b0, "R1 after reset");

    repeat (2) @(posedge clk);
    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule